// File: doc/BRIEF.md
# Conditional Branch and Jump Target Unit

This block resolves the control-flow instructions of an 8-bit microcontroller core that need arithmetic before the next fetch address is known. These are the accumulator-non-zero branch, the four compare-and-branch-if-different forms and the two decrement-and-branch-if-non-zero forms. It also computes the targets of the 2-byte paged absolute jump and the 3-byte long absolute jump. The fetch stage hands over the opcode byte and up to two following instruction bytes, together with the address of the opcode. The operand stage supplies the accumulator, the selected bank register and the byte that was read from memory (direct or indirect). Both arrive in a single-cycle valid/ready transfer.

One clock after a transfer is accepted, the unit presents a registered result for exactly one cycle. The result holds the next program counter, a taken flag, the number of machine clock cycles the instruction costs, an optional carry update and an optional write-back of the decremented byte, including where that byte goes. All relative offsets are measured from the address just past the instruction. Paged jumps stay inside the 2 KiB page of that address. Long jumps are limited to the 8 KiB code space. Any opcode outside the handled set follows the no-operation path.

Top module: `branch_exec_unit`

## Requirements
- R1: `in_ready` is 0 while `rst` is high and 1 from the first clock edge after reset. A transfer with `in_valid` and `in_ready` both high raises `out_valid` for exactly the next cycle. Reset clears `out_valid`, `taken`, `carry_we` and `wb_we`.
- R2: Opcode encodings and lengths are as follows. 0x70 is the accumulator branch (2 bytes). 0xB5 compares A with the memory byte, 0xB4 compares A with immediate `ins_b1`, 0xB8-0xBF compare register Rn with immediate `ins_b1`, and 0xB6/0xB7 compare the indirect memory byte with immediate `ins_b1` (all 3 bytes). 0xD8-0xDF decrement Rn (2 bytes) and 0xD5 decrements the memory byte (3 bytes). Any opcode with low five bits 00001 is the paged jump (2 bytes). 0x02 is the long jump (3 bytes).
- R3: For a taken conditional branch, `next_pc` = address + length + sign-extended offset, modulo 2^16. The offset is `ins_b1` for 2-byte forms and `ins_b2` for 3-byte forms. Offsets 0x80 (-128) and 0x7F (+127) are honoured, and results wrap across 256-byte pages and across 0xFFFF.
- R4: When a branch is not taken, `next_pc` = address + instruction length, modulo 2^16.
- R5: The accumulator branch is taken exactly when `acc` is non-zero.
- R6: A compare branch is taken when its two operands differ. It sets `carry` to 1 when the first operand is unsigned-less-than the second and to 0 otherwise, asserts `carry_we`, and never asserts `wb_we`.
- R7: A decrement branch writes back the operand minus one (0x00 becomes 0xFF) with `wb_we` = 1, and is taken when that result is non-zero. For the register form `wb_reg` = 1 and `wb_addr` = opcode bits 2:0. For the memory form `wb_reg` = 0, `wb_addr` = `ins_b1`, and `wb_sfr` = bit 7 of that address (0x80-0xFF selects the special register space).
- R8: Cycle counts (not taken / taken) are as follows: accumulator branch and register decrement 2/3; A-direct, A-immediate and Rn-immediate compares and memory decrement 3/4; indirect compare 4/5; paged jump 3; long jump 4; no-operation 1.
- R9: The paged jump target keeps bits 15:11 of (address + 2), takes opcode bits 7:5 as bits 10:8 and `ins_b1` as bits 7:0. The jump is always taken.
- R10: The long jump target is {`ins_b1`,`ins_b2`} with bits 15:13 cleared. The jump is always taken.
- R11: Opcodes 0x00 and 0xA5, and any opcode outside R2, give `next_pc` = address + 1, 1 cycle, `taken` = 0, `carry_we` = 0 and `wb_we` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Unit accepts a transfer |
| ins_op | input | 8 | Opcode byte |
| ins_b1 | input | 8 | Second instruction byte |
| ins_b2 | input | 8 | Third instruction byte |
| pc | input | 16 | Address of the opcode byte |
| acc | input | 8 | Accumulator value |
| rn_val | input | 8 | Value of the bank register named by the opcode |
| mem_val | input | 8 | Byte read from the direct or indirect location |
| out_valid | output | 1 | Result is valid this cycle |
| next_pc | output | 16 | Address of the next instruction to fetch |
| taken | output | 1 | Control transfer happened |
| cycles | output | 4 | Clock cycles used by the instruction |
| carry | output | 1 | New carry value |
| carry_we | output | 1 | Carry must be updated |
| wb_we | output | 1 | Decremented byte must be written back |
| wb_val | output | 8 | Decremented byte |
| wb_addr | output | 8 | Register number or direct address for the write-back |
| wb_reg | output | 1 | Write-back goes to a bank register |
| wb_sfr | output | 1 | Write-back goes to the special register space |

## Verification
The accumulator branch is swept over every accumulator value, so the zero case is separated from all non-zero ones. The decrement forms are swept over every operand value and every register number, and over addresses on both sides of 0x80, which exposes the 0x01 to 0x00 and 0x00 to 0xFF transitions and the space select. The four compare forms run on a grid of operand pairs plus every equal pair, which separates equal, less and greater and shows whether each form reads the right operand. Directed cases place offsets of -128 and +127 and page and 0xFFFF crossings against each instruction length, and put paged jumps on both sides of a 2 KiB boundary.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
  localparam int CYC_W = 4;

  typedef enum logic [3:0] {
    K_NOP, K_JNZ, K_CJ_ADIR, K_CJ_AIMM, K_CJ_RIMM, K_CJ_IND,
    K_DJ_REG, K_DJ_DIR, K_AJMP, K_LJMP
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [1:0]       len;
    logic [CYC_W-1:0] cyc_nt;
    logic [CYC_W-1:0] cyc_t;
  } dec_t;
endpackage

// File: rtl/bxu_decode.sv
module bxu_decode
  import bxu_pkg::*;
#(
  parameter int CYC_NOP   = 1,
  parameter int CYC_SHORT = 2,
  parameter int CYC_LONG  = 3,
  parameter int CYC_IND   = 4,
  parameter int CYC_EXTRA = 1,
  parameter int CYC_AJMP  = 3,
  parameter int CYC_LJMP  = 4
) (
  input  logic [7:0] op,
  output dec_t       d
);
  localparam logic [CYC_W-1:0] C_NOP  = CYC_W'(CYC_NOP);
  localparam logic [CYC_W-1:0] C_SH   = CYC_W'(CYC_SHORT);
  localparam logic [CYC_W-1:0] C_LG   = CYC_W'(CYC_LONG);
  localparam logic [CYC_W-1:0] C_IN   = CYC_W'(CYC_IND);
  localparam logic [CYC_W-1:0] C_SH_T = CYC_W'(CYC_SHORT + CYC_EXTRA);
  localparam logic [CYC_W-1:0] C_LG_T = CYC_W'(CYC_LONG + CYC_EXTRA);
  localparam logic [CYC_W-1:0] C_IN_T = CYC_W'(CYC_IND + CYC_EXTRA);
  localparam logic [CYC_W-1:0] C_AJ   = CYC_W'(CYC_AJMP);
  localparam logic [CYC_W-1:0] C_LJ   = CYC_W'(CYC_LJMP);

  always_comb begin
    d = '{kind: K_NOP, len: 2'd1, cyc_nt: C_NOP, cyc_t: C_NOP};
    casez (op)
      8'h70:       d = '{kind: K_JNZ,     len: 2'd2, cyc_nt: C_SH, cyc_t: C_SH_T};
      8'hB5:       d = '{kind: K_CJ_ADIR, len: 2'd3, cyc_nt: C_LG, cyc_t: C_LG_T};
      8'hB4:       d = '{kind: K_CJ_AIMM, len: 2'd3, cyc_nt: C_LG, cyc_t: C_LG_T};
      8'b1011_011?: d = '{kind: K_CJ_IND, len: 2'd3, cyc_nt: C_IN, cyc_t: C_IN_T};
      8'b1011_1???: d = '{kind: K_CJ_RIMM, len: 2'd3, cyc_nt: C_LG, cyc_t: C_LG_T};
      8'b1101_1???: d = '{kind: K_DJ_REG, len: 2'd2, cyc_nt: C_SH, cyc_t: C_SH_T};
      8'hD5:       d = '{kind: K_DJ_DIR,  len: 2'd3, cyc_nt: C_LG, cyc_t: C_LG_T};
      8'b???0_0001: d = '{kind: K_AJMP,   len: 2'd2, cyc_nt: C_AJ, cyc_t: C_AJ};
      8'h02:       d = '{kind: K_LJMP,    len: 2'd3, cyc_nt: C_LJ, cyc_t: C_LJ};
      default:     d = '{kind: K_NOP,     len: 2'd1, cyc_nt: C_NOP, cyc_t: C_NOP};
    endcase
  end
endmodule

// File: rtl/bxu_eval.sv
module bxu_eval
  import bxu_pkg::*;
#(
  parameter int DW = 8
) (
  input  kind_e         kind,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] rn_val,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] imm,
  output logic          take,
  output logic          carry,
  output logic          carry_we,
  output logic          wb_we,
  output logic [DW-1:0] wb_val
);
  logic [DW-1:0] lhs, rhs, dsrc, dres;

  always_comb begin
    unique case (kind)
      K_CJ_ADIR: begin lhs = acc;     rhs = mem_val; end
      K_CJ_AIMM: begin lhs = acc;     rhs = imm;     end
      K_CJ_RIMM: begin lhs = rn_val;  rhs = imm;     end
      K_CJ_IND:  begin lhs = mem_val; rhs = imm;     end
      default:   begin lhs = acc;     rhs = imm;     end
    endcase
    dsrc = (kind == K_DJ_REG) ? rn_val : mem_val;
    dres = dsrc - DW'(1);
  end

  always_comb begin
    take     = 1'b0;
    carry    = 1'b0;
    carry_we = 1'b0;
    wb_we    = 1'b0;
    wb_val   = '0;
    case (kind)
      K_JNZ: take = (acc != '0);
      K_CJ_ADIR, K_CJ_AIMM, K_CJ_RIMM, K_CJ_IND: begin
        take     = (lhs != rhs);
        carry    = (lhs < rhs);
        carry_we = 1'b1;
      end
      K_DJ_REG, K_DJ_DIR: begin
        wb_we  = 1'b1;
        wb_val = dres;
        take   = (dres != '0);
      end
      K_AJMP, K_LJMP: take = 1'b1;
      default: take = 1'b0;
    endcase
  end

  // R6
  always_comb begin
    if (carry_we && carry) begin
      cmp_carry_chk: assert (take) else $error("carry set on equal operands");
    end
  end
endmodule

// File: rtl/bxu_target.sv
module bxu_target
  import bxu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int CODE_W = 13
) (
  input  kind_e           kind,
  input  logic [1:0]      len,
  input  logic            take,
  input  logic [PC_W-1:0] pc,
  input  logic [7:0]      op,
  input  logic [7:0]      b1,
  input  logic [7:0]      b2,
  output logic [PC_W-1:0] next_pc
);
  localparam int PAGE_W = 11;

  logic [PC_W-1:0] seq, rel_tgt, page_tgt, long_tgt;
  logic [7:0]      rel;
  logic [15:0]     abs16;

  assign seq      = pc + PC_W'(len);
  assign rel      = (len == 2'd2) ? b1 : b2;
  assign rel_tgt  = seq + {{(PC_W-8){rel[7]}}, rel};
  assign page_tgt = {seq[PC_W-1:PAGE_W], op[7:5], b1};
  assign abs16    = {b1, b2};

  generate
    if (CODE_W < PC_W) begin : g_mask
      assign long_tgt = {{(PC_W-CODE_W){1'b0}}, abs16[CODE_W-1:0]};
    end else begin : g_full
      assign long_tgt = PC_W'(abs16);
    end
  endgenerate

  always_comb begin
    if (!take)                next_pc = seq;
    else if (kind == K_AJMP)  next_pc = page_tgt;
    else if (kind == K_LJMP)  next_pc = long_tgt;
    else                      next_pc = rel_tgt;
  end
endmodule

// File: rtl/branch_exec_unit.sv
module branch_exec_unit
  import bxu_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int CODE_W    = 13,
  parameter int CYC_NOP   = 1,
  parameter int CYC_SHORT = 2,
  parameter int CYC_LONG  = 3,
  parameter int CYC_IND   = 4,
  parameter int CYC_EXTRA = 1,
  parameter int CYC_AJMP  = 3,
  parameter int CYC_LJMP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       ins_op,
  input  logic [7:0]       ins_b1,
  input  logic [7:0]       ins_b2,
  input  logic [PC_W-1:0]  pc,
  input  logic [7:0]       acc,
  input  logic [7:0]       rn_val,
  input  logic [7:0]       mem_val,
  output logic             out_valid,
  output logic [PC_W-1:0]  next_pc,
  output logic             taken,
  output logic [CYC_W-1:0] cycles,
  output logic             carry,
  output logic             carry_we,
  output logic             wb_we,
  output logic [7:0]       wb_val,
  output logic [7:0]       wb_addr,
  output logic             wb_reg,
  output logic             wb_sfr
);
  dec_t            dec;
  logic            take_c, carry_c, carry_we_c, wb_we_c;
  logic [7:0]      wb_val_c, wb_addr_c;
  logic [PC_W-1:0] npc_c;
  logic            fire;

  bxu_decode #(
    .CYC_NOP(CYC_NOP), .CYC_SHORT(CYC_SHORT), .CYC_LONG(CYC_LONG),
    .CYC_IND(CYC_IND), .CYC_EXTRA(CYC_EXTRA), .CYC_AJMP(CYC_AJMP),
    .CYC_LJMP(CYC_LJMP)
  ) u_dec (.op(ins_op), .d(dec));

  bxu_eval #(.DW(8)) u_eval (
    .kind(dec.kind), .acc(acc), .rn_val(rn_val), .mem_val(mem_val),
    .imm(ins_b1), .take(take_c), .carry(carry_c), .carry_we(carry_we_c),
    .wb_we(wb_we_c), .wb_val(wb_val_c)
  );

  bxu_target #(.PC_W(PC_W), .CODE_W(CODE_W)) u_tgt (
    .kind(dec.kind), .len(dec.len), .take(take_c), .pc(pc), .op(ins_op),
    .b1(ins_b1), .b2(ins_b2), .next_pc(npc_c)
  );

  assign fire      = in_valid && in_ready;
  assign wb_addr_c = (dec.kind == K_DJ_REG) ? {5'd0, ins_op[2:0]} : ins_b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      cycles    <= '0;
      carry     <= 1'b0;
      carry_we  <= 1'b0;
      wb_we     <= 1'b0;
      wb_val    <= '0;
      wb_addr   <= '0;
      wb_reg    <= 1'b0;
      wb_sfr    <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= fire;
      if (fire) begin
        next_pc  <= npc_c;
        taken    <= take_c;
        cycles   <= take_c ? dec.cyc_t : dec.cyc_nt;
        carry    <= carry_c;
        carry_we <= carry_we_c;
        wb_we    <= wb_we_c;
        wb_val   <= wb_val_c;
        wb_addr  <= wb_we_c ? wb_addr_c : 8'd0;
        wb_reg   <= wb_we_c && (dec.kind == K_DJ_REG);
        wb_sfr   <= wb_we_c && (dec.kind == K_DJ_DIR) && ins_b1[7];
      end
    end
  end

  // R1
  resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));

  // R7
  djnz_take_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && wb_we) |-> (taken == (wb_val != 8'd0)));

  // R6
  wb_carry_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wb_we, carry_we}));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken) |->
      (((next_pc - $past(pc)) >= PC_W'(1)) && ((next_pc - $past(pc)) <= PC_W'(3))));

  // R8
  nt_cycles_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken) |-> (cycles >= CYC_W'(CYC_NOP) && cycles <= CYC_W'(CYC_IND)));
endmodule

// File: tb/branch_exec_unit_tb_top.sv
module branch_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  ins_op = 8'h00, ins_b1 = 8'h00, ins_b2 = 8'h00;
  logic [15:0] pc = 16'h0000;
  logic [7:0]  acc = 8'h00, rn_val = 8'h00, mem_val = 8'h00;
  logic        out_valid, taken, carry, carry_we, wb_we, wb_reg, wb_sfr;
  logic [15:0] next_pc;
  logic [3:0]  cycles;
  logic [7:0]  wb_val, wb_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  branch_exec_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .ins_op(ins_op), .ins_b1(ins_b1), .ins_b2(ins_b2), .pc(pc), .acc(acc),
    .rn_val(rn_val), .mem_val(mem_val), .out_valid(out_valid),
    .next_pc(next_pc), .taken(taken), .cycles(cycles), .carry(carry),
    .carry_we(carry_we), .wb_we(wb_we), .wb_val(wb_val), .wb_addr(wb_addr),
    .wb_reg(wb_reg), .wb_sfr(wb_sfr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected behaviour built from the requirement text
  task automatic run(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                     input logic [15:0] a_pc, input logic [7:0] a_acc,
                     input logic [7:0] a_rn, input logic [7:0] a_mem);
    int          len, cnt_nt, cnt_t;
    logic        e_take, e_cwe, e_c, e_wwe, e_wreg, e_wsfr, cond;
    logic [7:0]  l, r, e_wval, e_waddr, off;
    logic [15:0] seq, e_pc;
    string       pc_tag, fn_tag;
    cond = 1'b0; e_take = 1'b0; e_cwe = 1'b0; e_c = 1'b0; e_wwe = 1'b0;
    e_wreg = 1'b0; e_wsfr = 1'b0; e_wval = 8'h00; e_waddr = 8'h00;
    l = 8'h00; r = 8'h00; len = 1; cnt_nt = 1; cnt_t = 1; fn_tag = "R11";
    if (op == 8'h70) begin
      len = 2; cnt_nt = 2; cnt_t = 3; cond = 1'b1; e_take = (a_acc != 0); fn_tag = "R5";
    end else if (op == 8'hB5 || op == 8'hB4 || op[7:3] == 5'b10111 || op[7:1] == 7'b1011011) begin
      len = 3; cond = 1'b1; fn_tag = "R6"; e_cwe = 1'b1;
      cnt_nt = (op[7:1] == 7'b1011011) ? 4 : 3; cnt_t = cnt_nt + 1;
      if (op == 8'hB5)           begin l = a_acc; r = a_mem; end
      else if (op == 8'hB4)      begin l = a_acc; r = b1;    end
      else if (op[3])            begin l = a_rn;  r = b1;    end
      else                       begin l = a_mem; r = b1;    end
      e_take = (l != r); e_c = (l < r);
    end else if (op[7:3] == 5'b11011 || op == 8'hD5) begin
      cond = 1'b1; fn_tag = "R7"; e_wwe = 1'b1;
      if (op == 8'hD5) begin
        len = 3; cnt_nt = 3; e_wval = a_mem - 8'd1; e_waddr = b1; e_wsfr = b1[7];
      end else begin
        len = 2; cnt_nt = 2; e_wval = a_rn - 8'd1; e_waddr = {5'd0, op[2:0]}; e_wreg = 1'b1;
      end
      cnt_t = cnt_nt + 1; e_take = (e_wval != 0);
    end else if (op[4:0] == 5'b00001) begin
      len = 2; cnt_nt = 3; cnt_t = 3; e_take = 1'b1; fn_tag = "R9";
    end else if (op == 8'h02) begin
      len = 3; cnt_nt = 4; cnt_t = 4; e_take = 1'b1; fn_tag = "R10";
    end
    seq = a_pc + 16'(len);
    off = (len == 2) ? b1 : b2;
    if (!e_take)                  begin e_pc = seq; pc_tag = (len == 1) ? "R11" : "R4"; end
    else if (fn_tag == "R9")      begin e_pc = {seq[15:11], op[7:5], b1}; pc_tag = "R9"; end
    else if (fn_tag == "R10")     begin e_pc = {3'b000, b1[4:0], b2}; pc_tag = "R10"; end
    else                          begin e_pc = seq + {{8{off[7]}}, off}; pc_tag = "R3"; end

    @(negedge clk);
    chk("R1", "idle out_valid", 32'(out_valid), 32'd0);
    ins_op = op; ins_b1 = b1; ins_b2 = b2; pc = a_pc;
    acc = a_acc; rn_val = a_rn; mem_val = a_mem; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "out_valid", 32'(out_valid), 32'd1);
    chk(pc_tag, "next_pc", 32'(next_pc), 32'(e_pc));
    chk(fn_tag, "taken", 32'(taken), 32'(e_take));
    chk("R8", "cycles", 32'(cycles), 32'(e_take ? cnt_t : cnt_nt));
    chk(fn_tag, "carry_we", 32'(carry_we), 32'(e_cwe));
    chk(fn_tag, "wb_we", 32'(wb_we), 32'(e_wwe));
    if (e_cwe) chk("R6", "carry", 32'(carry), 32'(e_c));
    if (e_wwe) begin
      chk("R7", "wb_val", 32'(wb_val), 32'(e_wval));
      chk("R7", "wb_addr", 32'(wb_addr), 32'(e_waddr));
      chk("R7", "wb_reg", 32'(wb_reg), 32'(e_wreg));
      chk("R7", "wb_sfr", 32'(wb_sfr), 32'(e_wsfr));
    end
    if (cond && len == 2) chk("R2", "len2 form", 32'(e_take ? 1 : next_pc - a_pc), 32'(e_take ? 1 : 2));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "reset out_valid", 32'(out_valid), 32'd0);
    chk("R1", "reset in_ready", 32'(in_ready), 32'd0);
    chk("R1", "reset taken", 32'(taken), 32'd0);
    chk("R1", "reset wb_we/carry_we", 32'({wb_we, carry_we}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);

    // R5 every accumulator value
    for (int v = 0; v < 256; v++)
      run(8'h70, v[0] ? 8'h80 : 8'h7F, 8'h00, 16'(v * 257), v[7:0], 8'h00, 8'h00);

    // R6 compare grid plus equal pairs, all four forms
    for (int f = 0; f < 4; f++) begin
      logic [7:0] opc;
      opc = (f == 0) ? 8'hB5 : (f == 1) ? 8'hB4 : (f == 2) ? 8'hBB : 8'hB7;
      for (int x = 0; x < 256; x += 15) begin
        for (int y = 0; y < 256; y += 15) begin
          logic [7:0] first, second, other;
          first = x[7:0]; second = y[7:0]; other = ~first;
          case (f)
            0: run(opc, 8'h30, 8'hF0, 16'h1000, first, other, second);
            1: run(opc, second, 8'h10, 16'h2000, first, other, other);
            2: run(opc, second, 8'h85, 16'h3000, other, first, other);
            default: run(opc, second, 8'h7F, 16'h4000, other, other, first);
          endcase
        end
        case (f)
          0: run(opc, 8'h30, 8'hF0, 16'h1000, x[7:0], 8'h00, x[7:0]);
          1: run(opc, x[7:0], 8'h10, 16'h2000, x[7:0], 8'h00, 8'h00);
          2: run(opc, x[7:0], 8'h85, 16'h3000, 8'h00, x[7:0], 8'h00);
          default: run(opc, x[7:0], 8'h7F, 16'h4000, 8'h00, 8'h00, x[7:0]);
        endcase
      end
    end

    // R7 register form: every register and value
    for (int rg = 0; rg < 8; rg++)
      for (int v = 0; v < 256; v++)
        run(8'hD8 | 8'(rg), 8'(v), 8'h00, 16'h5000, 8'h00, 8'(v), 8'h00);
    // R7 memory form on both sides of 0x80
    for (int ai = 0; ai < 4; ai++)
      for (int v = 0; v < 256; v++)
        run(8'hD5, (ai == 0) ? 8'h00 : (ai == 1) ? 8'h7F : (ai == 2) ? 8'h80 : 8'hFF,
            8'(v), 16'h6000, 8'h00, 8'h00, 8'(v));

    // R3 offset extremes and wraps
    run(8'h70, 8'h80, 8'h00, 16'h0200, 8'h01, 8'h00, 8'h00);
    run(8'h70, 8'h7F, 8'h00, 16'h0200, 8'h01, 8'h00, 8'h00);
    run(8'hB4, 8'h01, 8'h7F, 16'h0300, 8'h02, 8'h00, 8'h00);
    run(8'hB4, 8'h01, 8'h80, 16'h0300, 8'h02, 8'h00, 8'h00);
    run(8'h70, 8'h20, 8'h00, 16'h00F0, 8'h01, 8'h00, 8'h00);
    run(8'h70, 8'h05, 8'h00, 16'hFFFE, 8'h01, 8'h00, 8'h00);
    run(8'h70, 8'h80, 8'h00, 16'h0001, 8'h01, 8'h00, 8'h00);
    run(8'hD5, 8'h10, 8'h7F, 16'hFFF0, 8'h00, 8'h00, 8'h05);
    run(8'hDF, 8'hFE, 8'h00, 16'h0000, 8'h00, 8'h03, 8'h00);

    // R9 paged jumps across a 2 KiB boundary
    for (int hi = 0; hi < 8; hi++) begin
      run({3'(hi), 5'b00001}, 8'hA5, 8'h00, 16'h07FD, 8'h00, 8'h00, 8'h00);
      run({3'(hi), 5'b00001}, 8'h3C, 8'h00, 16'h07FE, 8'h00, 8'h00, 8'h00);
      run({3'(hi), 5'b00001}, 8'hFF, 8'h00, 16'hFFFE, 8'h00, 8'h00, 8'h00);
      run({3'(hi), 5'b00001}, 8'h00, 8'h00, 16'h1234, 8'h00, 8'h00, 8'h00);
    end

    // R10 long jumps, upper bits discarded
    run(8'h02, 8'hFF, 8'hFF, 16'h0100, 8'h00, 8'h00, 8'h00);
    run(8'h02, 8'h12, 8'h34, 16'hFFFD, 8'h00, 8'h00, 8'h00);
    run(8'h02, 8'hE0, 8'h01, 16'h0000, 8'h00, 8'h00, 8'h00);

    // R11 no-operation codes
    run(8'h00, 8'h12, 8'h34, 16'h0040, 8'h01, 8'h02, 8'h03);
    run(8'hA5, 8'h12, 8'h34, 16'h0040, 8'h01, 8'h02, 8'h03);
    run(8'hA5, 8'hFF, 8'hFF, 16'hFFFF, 8'h00, 8'h00, 8'h00);
    run(8'h04, 8'h00, 8'h00, 16'h0777, 8'h55, 8'h00, 8'h00);

    @(negedge clk);
    chk("R1", "final idle", 32'(out_valid), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule